// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed memory in which each word has one extra presence bit. The bit marks the word as holding a value (full) or not (empty). Two threads can hand values to each other through such a word. The producer writes only into an empty slot and marks it full. The consumer reads only from a full slot and marks it empty. Whenever the presence bit does not allow an access, the access is refused with a trap so that software can retry it. Plain reads and writes pass the presence bit by unchanged. A peek operation returns the word and reports through trap or done whether it was present, without consuming it.

One request can arrive on every clock, and there is no backpressure. The presence bit of the addressed word is tested and updated at the same clock edge that accepts the request. The next request therefore always sees the result of the one before it. Each request produces a single registered response cycle. Trap handling, retry policy and coherence with any cache belong to the surrounding system.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every presence bit is empty, every data word is zero, and neither rsp_done nor rsp_trap is high.
- R2: A request sampled at a rising edge gives exactly one response in the following cycle, in which exactly one of rsp_done and rsp_trap is high. A cycle with no request gives a cycle in which both are low.
- R3: A plain write (req_op = 1) stores req_wdata, responds with done and leaves the word's presence bit unchanged.
- R4: A plain read (req_op = 0) returns the stored word on rsp_rdata, responds with done and leaves the presence bit unchanged.
- R5: A producing write (req_op = 3) to an empty word stores req_wdata, sets the presence bit to full and responds with done.
- R6: A producing write to a full word changes neither the data nor the presence bit, and responds with trap.
- R7: A consuming read (req_op = 2) from a full word returns the word, sets the presence bit to empty and responds with done.
- R8: A consuming read from an empty word responds with trap and rsp_rdata = 0, and the presence bit stays empty.
- R9: A peek (req_op = 4) returns the stored word on rsp_rdata, responds with done if the word is full and with trap if it is empty, and never changes the presence bit.
- R10: Opcodes 5 to 7 are reserved. They respond with trap and rsp_rdata = 0 and change neither data nor presence bits.
- R11: A request in the cycle directly after another request to the same word sees the data and presence bit left by the earlier request.
- R12: Responses to write requests (opcodes 1 and 3) carry rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present in this cycle |
| req_op | input | 3 | Opcode: 0 read, 1 write, 2 consuming read, 3 producing write, 4 peek, 5 to 7 reserved |
| req_addr | input | ADDR_W (4) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_rdata | output | DATA_W (16) | Returned word, or zero as stated per opcode |
| rsp_done | output | 1 | The request completed |
| rsp_trap | output | 1 | The request was refused or only reported an empty word |

## Verification
The assertions assume that req_op, req_addr and req_valid carry known values in every cycle after reset. They also assume that a request is judged only against the presence bits as they stand at its accepting edge. The stimulus drives every input on the falling edge, holds it stable across the rising edge, and parks valid low with defined op and address between scenarios. The presence bits are observed only through peek requests, which the requirements define as non-consuming. The back-to-back scenario keeps valid high over consecutive edges. This makes the second request depend on the bit update made by the first.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_CONSUME = 3'd2,
        OP_PRODUCE = 3'd3,
        OP_PEEK    = 3'd4
    } fe_op_e;

    typedef struct packed {
        logic done;
        logic trap;
        logic ret_data;
        logic mem_we;
        logic tag_we;
        logic tag_val;
    } fe_verdict_t;

endpackage

// File: rtl/fe_rule.sv
module fe_rule
    import fe_pkg::*;
(
    input  logic        valid,
    input  logic [2:0]  op,
    input  logic        tag_now,
    output fe_verdict_t verdict
);
    always_comb begin
        verdict = '0;
        if (valid) begin
            unique case (op)
                OP_READ: begin
                    verdict.done     = 1'b1;
                    verdict.ret_data = 1'b1;
                end
                OP_WRITE: begin
                    verdict.done   = 1'b1;
                    verdict.mem_we = 1'b1;
                end
                OP_CONSUME: begin
                    if (tag_now) begin
                        verdict.done     = 1'b1;
                        verdict.ret_data = 1'b1;
                        verdict.tag_we   = 1'b1;
                        verdict.tag_val  = 1'b0;
                    end else begin
                        verdict.trap = 1'b1;
                    end
                end
                OP_PRODUCE: begin
                    if (!tag_now) begin
                        verdict.done    = 1'b1;
                        verdict.mem_we  = 1'b1;
                        verdict.tag_we  = 1'b1;
                        verdict.tag_val = 1'b1;
                    end else begin
                        verdict.trap = 1'b1;
                    end
                end
                OP_PEEK: begin
                    verdict.ret_data = 1'b1;
                    verdict.done     = tag_now;
                    verdict.trap     = !tag_now;
                end
                default: begin
                    verdict.trap = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_val,
    output logic [DEPTH-1:0]  tags
);
    logic [DEPTH-1:0] tags_d, tags_q;

    always_comb begin
        tags_d = tags_q;
        if (upd_en) begin
            tags_d[upd_addr] = upd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags_q <= '0;
        end else begin
            tags_q <= tags_d;
        end
    end

    assign tags = tags_q;
endmodule

// File: rtl/fe_word_array.sv
module fe_word_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_comb begin
            mem_d[i] = mem_q[i];
            if (we && (addr == ADDR_W'(i))) begin
                mem_d[i] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
    import fe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_trap
);
    typedef struct packed {
        logic              done;
        logic              trap;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    fe_verdict_t       verdict;
    logic [DEPTH-1:0]  tag_vec;
    logic [DATA_W-1:0] word_now;

    fe_tag_array #(.ADDR_W(ADDR_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (verdict.tag_we),
        .upd_addr (req_addr),
        .upd_val  (verdict.tag_val),
        .tags     (tag_vec)
    );

    fe_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_words (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (verdict.mem_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (word_now)
    );

    fe_rule u_rule (
        .valid   (req_valid),
        .op      (req_op),
        .tag_now (tag_vec[req_addr]),
        .verdict (verdict)
    );

    always_comb begin
        rsp_d      = '0;
        rsp_d.done = verdict.done;
        rsp_d.trap = verdict.trap;
        if (verdict.ret_data) begin
            rsp_d.data = word_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_rdata = rsp_q.data;
    assign rsp_done  = rsp_q.done;
    assign rsp_trap  = rsp_q.trap;
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_done,
    input logic              rsp_trap,
    input logic [DEPTH-1:0]  tag_vec
);
    p_one_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_done ^ rsp_trap));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_done && !rsp_trap));

    p_idle_tags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(tag_vec));

    p_plain_tags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd0 || req_op == 3'd1 || req_op == 3'd4 || req_op > 3'd4))
        |=> $stable(tag_vec));

    p_produce_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && !tag_vec[req_addr])
        |=> (rsp_done && tag_vec[$past(req_addr)] && rsp_rdata == '0));

    p_produce_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && tag_vec[req_addr])
        |=> (rsp_trap && $stable(tag_vec)));

    p_consume_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2 && tag_vec[req_addr])
        |=> (rsp_done && !tag_vec[$past(req_addr)]));

    p_consume_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2 && !tag_vec[req_addr])
        |=> (rsp_trap && rsp_rdata == '0 && $stable(tag_vec)));

    p_peek_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4)
        |=> (rsp_done == $past(tag_vec[req_addr])));
endmodule

bind fe_sync_mem fe_sync_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done),
    .rsp_trap  (rsp_trap),
    .tag_vec   (tag_vec)
);

// File: tb/fe_sync_mem_bench.sv
module fe_sync_mem_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_done;
    logic              rsp_trap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    fe_sync_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fe_sync_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .rsp_done  (rsp_done),
        .rsp_trap  (rsp_trap)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one request; response sampled at the falling edge after the accepting edge
    task automatic xact(input logic [2:0] op, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] wd, input string req,
                        input logic exp_done, input logic [DATA_W-1:0] exp_data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " done"}, 32'(rsp_done), 32'(exp_done));
        chk({req, " trap"}, 32'(rsp_trap), 32'(!exp_done));
        chk({req, " data"}, 32'(rsp_rdata), 32'(exp_data));
    endtask

    task automatic t_reset;
        chk("R1 reset done", 32'(rsp_done), 0);
        chk("R1 reset trap", 32'(rsp_trap), 0);
        xact(3'd0, 4'd3, '0, "R1 R4 read after reset", 1'b1, 16'h0000);
        xact(3'd4, 4'd3, '0, "R1 R9 peek after reset empty", 1'b0, 16'h0000);
        @(negedge clk);
        chk("R2 idle done", 32'(rsp_done), 0);
        chk("R2 idle trap", 32'(rsp_trap), 0);
    endtask

    task automatic t_plain;
        xact(3'd1, 4'd2, 16'hA5A5, "R3 R12 plain write", 1'b1, 16'h0000);
        xact(3'd0, 4'd2, '0, "R4 plain read", 1'b1, 16'hA5A5);
        xact(3'd4, 4'd2, '0, "R3 write keeps tag empty", 1'b0, 16'hA5A5);
    endtask

    task automatic t_produce;
        xact(3'd3, 4'd5, 16'h1234, "R5 R12 produce into empty", 1'b1, 16'h0000);
        xact(3'd4, 4'd5, '0, "R5 R9 peek full", 1'b1, 16'h1234);
        xact(3'd3, 4'd5, 16'h9999, "R6 produce into full", 1'b0, 16'h0000);
        xact(3'd0, 4'd5, '0, "R6 data unchanged", 1'b1, 16'h1234);
        xact(3'd4, 4'd5, '0, "R6 R4 tag still full", 1'b1, 16'h1234);
    endtask

    task automatic t_consume;
        xact(3'd2, 4'd5, '0, "R7 consume full", 1'b1, 16'h1234);
        xact(3'd4, 4'd5, '0, "R7 R9 tag empty after consume", 1'b0, 16'h1234);
        xact(3'd2, 4'd5, '0, "R8 consume empty", 1'b0, 16'h0000);
        xact(3'd4, 4'd5, '0, "R8 tag stays empty", 1'b0, 16'h1234);
    endtask

    task automatic t_plain_on_full;
        xact(3'd3, 4'd7, 16'h0BEE, "R5 produce word 7", 1'b1, 16'h0000);
        xact(3'd1, 4'd7, 16'h0C0F, "R3 plain write on full", 1'b1, 16'h0000);
        xact(3'd4, 4'd7, '0, "R3 tag still full after write", 1'b1, 16'h0C0F);
        xact(3'd0, 4'd7, '0, "R4 plain read on full", 1'b1, 16'h0C0F);
        xact(3'd4, 4'd7, '0, "R4 read did not consume", 1'b1, 16'h0C0F);
    endtask

    task automatic t_reserved;
        for (int op = 5; op < 8; op++) begin
            xact(3'(op), 4'd7, 16'hDEAD, "R10 reserved op", 1'b0, 16'h0000);
        end
        xact(3'd4, 4'd7, '0, "R10 state untouched", 1'b1, 16'h0C0F);
        xact(3'd6, 4'd8, 16'hDEAD, "R10 reserved on empty", 1'b0, 16'h0000);
        xact(3'd0, 4'd8, '0, "R10 no write on empty", 1'b1, 16'h0000);
    endtask

    task automatic t_back_to_back;
        // produce then consume in consecutive cycles
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd3; req_addr = 4'd9; req_wdata = 16'h7777;
        @(negedge clk);
        chk("R11 first produce done", 32'(rsp_done), 1);
        req_op = 3'd2;
        @(negedge clk);
        chk("R11 consume sees fill done", 32'(rsp_done), 1);
        chk("R11 consume sees fill data", 32'(rsp_rdata), 32'h7777);
        // two produces in consecutive cycles: second must trap
        req_op = 3'd3; req_wdata = 16'h1111;
        @(negedge clk);
        chk("R11 produce after consume done", 32'(rsp_done), 1);
        req_wdata = 16'h2222;
        @(negedge clk);
        chk("R11 second produce trap", 32'(rsp_trap), 1);
        chk("R2 second produce not done", 32'(rsp_done), 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle after burst", 32'(rsp_done | rsp_trap), 0);
        xact(3'd0, 4'd9, '0, "R11 kept first data", 1'b1, 16'h1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_produce();
        t_consume();
        t_plain_on_full();
        t_reserved();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule